// File: doc/BRIEF.md
# Paired-Counter PWM Output Generator

This block makes one pulse-width-modulated output from two down-counters. A period counter fixes the length of each PWM cycle, and a duty counter that it restarts fixes how long the output stays active. An output stage turns counter events into the pin level. It runs in one of two modes. In set/reset mode the active level can be chosen. In toggle mode the pin inverts once per period. An enable bit decides whether the timer or software owns the pin.

Software reaches the block through a small write-only port with four addresses: 0 holds the period value M, 1 holds the duty value D, 2 is the control register and 3 is the output bit. The control register bits are: bit 0 run, bit 1 mode (1 = set/reset, 0 = toggle), bit 2 polarity (1 = active-low, 0 = active-high) and bit 3 output enable. A write to address 3 takes its value from data bit 0. The counters advance only in cycles where `cnt_en` is high and run is set. One of these cycles is called a tick.

Top module: `pwm_pair_timer`

## Requirements
- R1: After a synchronous reset `out_pin`, `mst_irq` and `slv_irq` are all low, and the timer is stopped with the output enable clear.
- R2: While running, `mst_irq` pulses once every M+1 ticks. The first pulse comes on the first tick after run is set, and counting stalls in cycles where `cnt_en` is low.
- R3: The values at addresses 0 and 1 reach the counters only on the tick where the period counter raises its interrupt. A duty write in the middle of a period leaves that period's pulse width unchanged and applies from the following period.
- R4: In set/reset mode with active-high polarity and 0 < D <= M, `out_pin` is high for D of every M+1 ticks. The set happens on the tick after the period interrupt.
- R5: A duty value of 0 gives 0 % duty. The set and reset events fall on the same tick, and reset takes priority.
- R6: A duty value greater than M gives 100 % duty.
- R7: With polarity bit 2 set, the set/reset output is inverted, so its high time is M+1-D ticks per period.
- R8: A polarity change while running leaves `out_pin` unchanged. The new polarity takes effect at the next set or reset event.
- R9: In toggle mode the pin starts from the level written at address 3 and inverts on every period interrupt, whatever the polarity bit says.
- R10: While the output enable is clear, timer events do not change `out_pin`, and a write to address 3 sets the pin to data bit 0.
- R11: While the output enable is set, a timer output change that falls in the same cycle as a write to address 3 is applied, and the software value is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CW | Write data |
| out_pin | output | 1 | PWM output level |
| mst_irq | output | 1 | Period interrupt pulse |
| slv_irq | output | 1 | Duty interrupt pulse |

## Verification
The assertions check several rules on every cycle. Each counter decrements cleanly between reloads. Period interrupts occur only after a count-enable cycle. A coincident set and reset leaves the inactive level. The pin holds still when no event or write occurs, and that includes the cycle of a polarity change. Toggle events always invert the pin. The bench scenarios cover what only a sequence can show: the duty ratio at 0, mid-range, the period value and above it, in both polarities and with a sparse count enable. They also show that a mid-period duty write is deferred by one period, that toggle mode starts from the software-set default, and that a timer event wins over a coincident software write.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 2'd0,
    A_DUTY   = 2'd1,
    A_CTRL   = 2'd2,
    A_OUTBIT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic oe;     // bit 3
    logic lvl;    // bit 2: 1 = active-low
    logic combo;  // bit 1: 1 = set/reset mode
    logic run;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/pwm_master_cnt.sv
module pwm_master_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] reload,
  output logic          evt,
  output logic          irq_q
);
  logic [CW-1:0] cnt;

  assign evt = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (evt)     cnt <= reload;
    else if (tick)    cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= evt;
  end

  assert_period_dec_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/pwm_slave_cnt.sv
module pwm_slave_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          trig,
  input  logic [CW-1:0] reload,
  output logic          set_evt,
  output logic          rst_evt,
  output logic          irq_q
);
  logic [CW-1:0] cnt;
  logic          act;
  logic          pend;

  assign rst_evt = tick && act && (cnt == '0);
  assign set_evt = tick && pend;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      act  <= 1'b0;
      pend <= 1'b0;
    end else if (tick) begin
      pend <= trig;
      if (trig) begin
        cnt <= reload;
        act <= 1'b1;
      end else if (rst_evt) begin
        act <= 1'b0;
      end else if (act) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= rst_evt;
  end

  // reload only via the period interrupt (R3)
  assert_duty_no_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !trig && act && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/pwm_out_ctl.sv
module pwm_out_ctl (
  input  logic clk,
  input  logic rst,
  input  logic combo,
  input  logic lvl,
  input  logic oe,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic tog_evt,
  input  logic set_evt,
  input  logic rst_evt,
  output logic out_q
);
  logic act_lvl;
  logic tev;
  logic nxt;

  assign act_lvl = ~lvl;
  assign tev     = combo ? (set_evt || rst_evt) : tog_evt;

  always_comb begin
    if (oe && tev) begin
      if (combo) nxt = rst_evt ? ~act_lvl : act_lvl;
      else       nxt = ~out_q;
    end else if (sw_wr) begin
      nxt = sw_val;
    end else begin
      nxt = out_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= nxt;
  end

  assert_reset_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (oe && combo && set_evt && rst_evt) |=> (out_q == $past(lvl)));
  assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (rst)
    (oe && !combo && tog_evt) |=> (out_q != $past(out_q)));
  assert_gate_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!oe && !sw_wr) |=> $stable(out_q));
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (oe && !sw_wr && !set_evt && !rst_evt && !tog_evt) |=> $stable(out_q));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_pin,
  output logic          mst_irq,
  output logic          slv_irq
);
  import pwm_pair_pkg::*;

  logic [CW-1:0] period_q;
  logic [CW-1:0] duty_q;
  ctrl_t         ctrl_q;
  logic          tick;
  logic          m_evt;
  logic          s_set;
  logic          s_rst;
  logic          sw_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: period_q <= wr_data;
        A_DUTY:   duty_q   <= wr_data;
        A_CTRL:   ctrl_q   <= ctrl_t'(wr_data[3:0]);
        default:  ;
      endcase
    end
  end

  assign tick  = cnt_en && ctrl_q.run;
  assign sw_wr = wr_en && (wr_addr == A_OUTBIT);

  pwm_master_cnt #(.CW(CW)) u_master (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick),
    .reload(period_q), .evt(m_evt), .irq_q(mst_irq)
  );

  pwm_slave_cnt #(.CW(CW)) u_slave (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .tick(tick), .trig(m_evt),
    .reload(duty_q), .set_evt(s_set), .rst_evt(s_rst), .irq_q(slv_irq)
  );

  pwm_out_ctl u_out (
    .clk(clk), .rst(rst), .combo(ctrl_q.combo), .lvl(ctrl_q.lvl),
    .oe(ctrl_q.oe), .sw_wr(sw_wr), .sw_val(wr_data[0]),
    .tog_evt(m_evt), .set_evt(s_set), .rst_evt(s_rst), .out_q(out_pin)
  );

  assert_irq_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    mst_irq |-> $past(cnt_en));
  assert_duty_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    slv_irq |-> $past(cnt_en));
endmodule

// File: tb/tb_pwm_pair_timer.sv
module tb_pwm_pair_timer;
  localparam int CW = 16;
  localparam logic [CW-1:0] C_RUN = 1, C_COMBO = 2, C_LVL = 4, C_OE = 8;

  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic out_pin, mst_irq, slv_irq;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  pwm_pair_timer #(.CW(CW)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_pin(out_pin), .mst_irq(mst_irq), .slv_irq(slv_irq)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int m, int d, logic [CW-1:0] bits, logic dflt);
    wr(2, '0); wr(0, CW'(m)); wr(1, CW'(d)); wr(3, CW'(dflt));
    wr(2, bits | C_RUN);
    repeat (3 * (m + 1) + 3) @(negedge clk);
  endtask

  task automatic window(int n, bit sparse, output int hi, output int irqs);
    hi = 0; irqs = 0;
    for (int i = 0; i < n; i++) begin
      if (sparse) cnt_en = ~cnt_en;
      @(negedge clk);
      if (out_pin) hi++;
      if (mst_irq) irqs++;
    end
    cnt_en = 1'b1;
  endtask

  task automatic wait_irq();
    while (!mst_irq) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out", out_pin, 0);
    chk("R1 mst_irq", mst_irq, 0);
    chk("R1 slv_irq", slv_irq, 0);
  endtask

  task automatic t_duty();
    int h, n;
    cfg(9, 3, C_COMBO | C_OE, 0);
    window(40, 0, h, n);
    chk("R2 period irqs", n, 4);
    chk("R4 duty 3/10", h, 12);
    window(80, 1, h, n);
    chk("R2 sparse irqs", n, 4);
    chk("R4 sparse duty", h, 24);
    cfg(9, 9, C_COMBO | C_OE, 0);
    window(40, 0, h, n);
    chk("R4 duty D=M", h, 36);
    cfg(9, 0, C_COMBO | C_OE, 0);
    window(40, 0, h, n);
    chk("R5 zero duty", h, 0);
    cfg(9, 12, C_COMBO | C_OE, 0);
    window(40, 0, h, n);
    chk("R6 full duty", h, 40);
  endtask

  task automatic t_polarity();
    int h, n;
    cfg(9, 3, C_COMBO | C_OE | C_LVL, 0);
    window(40, 0, h, n);
    chk("R7 inverted duty", h, 28);
    cfg(9, 0, C_COMBO | C_OE | C_LVL, 0);
    window(40, 0, h, n);
    chk("R7 inverted zero duty", h, 40);
  endtask

  task automatic t_level_change();
    int h, n;
    cfg(9, 3, C_COMBO | C_OE, 0);
    wait_irq();
    @(negedge clk);
    wr(2, C_RUN | C_COMBO | C_OE | C_LVL);
    chk("R8 no immediate change", out_pin, 1);
    repeat (30) @(negedge clk);
    window(40, 0, h, n);
    chk("R8 new polarity later", h, 28);
  endtask

  task automatic t_mid_write();
    int h;
    cfg(9, 3, C_COMBO | C_OE, 0);
    wait_irq();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd6;
    h = 0;
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      if (mst_irq) break;
      if (out_pin) h++;
    end
    chk("R3 current period keeps old duty", h, 3);
    h = 0;
    forever begin
      @(negedge clk);
      if (mst_irq) break;
      if (out_pin) h++;
    end
    chk("R3 next period uses new duty", h, 6);
  endtask

  task automatic t_toggle();
    int h, n;
    wr(2, '0); wr(0, 16'd4); wr(3, 16'd1);
    wr(2, C_OE | C_LVL);
    chk("R9 default level", out_pin, 1);
    wr(2, C_OE | C_LVL | C_RUN);
    @(negedge clk);
    chk("R9 first irq", mst_irq, 1);
    chk("R9 first toggle", out_pin, 0);
    window(40, 0, h, n);
    chk("R9 toggle duty", h, 20);
  endtask

  task automatic t_gate();
    int h, n;
    cfg(4, 2, C_COMBO, 1);
    window(20, 0, h, n);
    chk("R10 gated hold", h, 20);
    wr(3, 16'd0);
    chk("R10 software level", out_pin, 0);
    window(20, 0, h, n);
    chk("R10 gated hold low", h, 0);
  endtask

  task automatic t_coincide();
    logic saved;
    cfg(3, 0, C_OE, 0);
    wait_irq();
    repeat (3) @(negedge clk);
    saved = out_pin;
    wr(3, CW'(saved));
    chk("R11 irq same cycle", mst_irq, 1);
    chk("R11 timer change wins", out_pin, int'(!saved));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_duty();
    t_polarity();
    t_level_change();
    t_mid_write();
    t_toggle();
    t_gate();
    t_coincide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule